// File: doc/BRIEF.md
# Read Sample Delay Controller

This block sets the point at which read data is captured after the rising edge of the read strobe. The point is delayed by a programmable number of eighths of a reference period. The reference period is either one whole core clock period or half of one. The block runs on a fast oversampling clock, and each of its edges is one tick. `OVERSAMPLE` ticks make one core clock. The bus sequencer gives the block a one-tick pulse at each read-strobe rise. The block returns a one-tick capture pulse, either at that same tick or a computed number of ticks later.

The delay factor and the half-period select are held in a small configuration store. This store accepts writes only while the unit is disabled. Once the unit is enabled, a settling window of `SETTLE_CLKS` core clocks must pass before the ready status rises. While the unit is disabled, captures are undelayed and the ready status is low.

Top module: `rd_sample_delay`

## Requirements
- R1: After reset, capture and ready are low, and the stored delay factor and half-period select are both zero. An enabled strobe after reset is therefore captured at once.
- R2: A configuration write (cfg_wr high) is stored only in a tick where enable is low. A write in a tick where enable is high has no effect on later delays.
- R3: A requested factor (6-bit cfg_factor) above 15 is stored as 15, the largest value of the 4-bit factor field.
- R4: With the defaults (16 ticks per clock, 64 clocks), ready is low after 1023 ticks of continuous enable and high after 1024 ticks.
- R5: In full-period mode (half select 0) with enable high and factor F > 0, capture pulses exactly 2*F ticks after the strobe tick.
- R6: In half-period mode (half select 1) with enable high and factor F > 0, capture pulses exactly F ticks after the strobe tick.
- R7: With enable high and a stored factor of 0, capture pulses in the same tick as the strobe.
- R8: While enable is low, capture equals the strobe in the same tick and ready is low at once. Clearing enable also cancels any pending delayed capture.
- R9: A new strobe while a delayed capture is still pending restarts the delay. Exactly one capture follows, timed from the newer strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oversampling clock; one edge per tick |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Unit enable; while high the delay applies and settling counts |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_factor | input | 6 | Requested delay factor in eighths of the reference period |
| cfg_half | input | 1 | Reference-period select: 1 selects half a clock period |
| strobe_rise | input | 1 | One-tick pulse marking the read-strobe rising edge |
| capture | output | 1 | One-tick data capture pulse |
| ready | output | 1 | High once the settling window has elapsed under enable |

## Verification
The hardest case to reach from the ports is a second strobe arriving while a delayed capture is still counting down. Disabling the unit and rewriting the configuration both cancel the pending count, so neither can be used to set this case up. The stimulus therefore fixes a long full-period delay, issues one strobe, and issues a second strobe a few ticks later. It then checks that exactly one capture appears, timed from the second strobe. Writes attempted while enabled are placed between every configuration and its measurement, so that the ignored-write rule is tested on each random pass.

// File: rtl/rsd_pkg.sv
package rsd_pkg;
    localparam int unsigned DEF_FACTOR_W   = 4;
    localparam int unsigned DEF_CFG_W      = 6;
    localparam int unsigned DEF_OVERSAMPLE = 16;
    localparam int unsigned DEF_SETTLE_CLK = 64;

    // ticks represented by one unit of the factor: an eighth of a full or half period
    function automatic int unsigned ticks_per_step(input int unsigned oversample, input bit half);
        return half ? oversample / 16 : oversample / 8;
    endfunction
endpackage

// File: rtl/rsd_cfg.sv
module rsd_cfg #(
    parameter int unsigned FACTOR_W = rsd_pkg::DEF_FACTOR_W,
    parameter int unsigned CFG_W    = rsd_pkg::DEF_CFG_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                enable,
    input  logic                wr,
    input  logic [CFG_W-1:0]    factor_in,
    input  logic                half_in,
    output logic [FACTOR_W-1:0] factor_q,
    output logic                half_q
);
    localparam int unsigned FMAX = (1 << FACTOR_W) - 1;

    typedef struct packed {
        logic [FACTOR_W-1:0] factor;
        logic                half;
    } cfg_t;

    cfg_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr && !enable) begin
            if (factor_in > CFG_W'(FMAX))
                st_d.factor = FACTOR_W'(FMAX);
            else
                st_d.factor = factor_in[FACTOR_W-1:0];
            st_d.half = half_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign factor_q = st_q.factor;
    assign half_q   = st_q.half;
endmodule

// File: rtl/rsd_settle.sv
module rsd_settle #(
    parameter int unsigned LIMIT = rsd_pkg::DEF_SETTLE_CLK * rsd_pkg::DEF_OVERSAMPLE
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    output logic settled
);
    localparam int unsigned CNT_W = $clog2(LIMIT + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } settle_t;

    settle_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!enable)
            st_d.cnt = '0;
        else if (st_q.cnt != CNT_W'(LIMIT))
            st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign settled = (st_q.cnt == CNT_W'(LIMIT));
endmodule

// File: rtl/rsd_delay.sv
module rsd_delay #(
    parameter int unsigned FACTOR_W   = rsd_pkg::DEF_FACTOR_W,
    parameter int unsigned OVERSAMPLE = rsd_pkg::DEF_OVERSAMPLE
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                enable,
    input  logic [FACTOR_W-1:0] factor,
    input  logic                half,
    input  logic                strobe,
    output logic                capture
);
    localparam int unsigned FULL_STEP = rsd_pkg::ticks_per_step(OVERSAMPLE, 1'b0);
    localparam int unsigned HALF_STEP = rsd_pkg::ticks_per_step(OVERSAMPLE, 1'b1);
    localparam int unsigned FMAX      = (1 << FACTOR_W) - 1;
    localparam int unsigned REM_W     = $clog2(FMAX * FULL_STEP + 1);

    typedef struct packed {
        logic [REM_W-1:0] rem;
    } dly_t;

    dly_t             st_d, st_q;
    logic             bypass;
    logic             launch;
    logic [REM_W-1:0] ticks;

    always_comb begin
        bypass = !enable || (factor == '0);
        launch = strobe && !bypass;
        ticks  = half ? REM_W'(factor * HALF_STEP) : REM_W'(factor * FULL_STEP);
        st_d   = st_q;
        if (!enable)
            st_d.rem = '0;
        else if (launch)
            st_d.rem = ticks;
        else if (st_q.rem != '0)
            st_d.rem = st_q.rem - 1'b1;
        capture = (bypass && strobe) ||
                  (enable && !launch && (st_q.rem == REM_W'(1)));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/rd_sample_delay.sv
module rd_sample_delay #(
    parameter int unsigned FACTOR_W    = rsd_pkg::DEF_FACTOR_W,
    parameter int unsigned CFG_W       = rsd_pkg::DEF_CFG_W,
    parameter int unsigned OVERSAMPLE  = rsd_pkg::DEF_OVERSAMPLE,
    parameter int unsigned SETTLE_CLKS = rsd_pkg::DEF_SETTLE_CLK
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             cfg_wr,
    input  logic [CFG_W-1:0] cfg_factor,
    input  logic             cfg_half,
    input  logic             strobe_rise,
    output logic             capture,
    output logic             ready
);
    localparam int unsigned SETTLE_TICKS = SETTLE_CLKS * OVERSAMPLE;

    logic [FACTOR_W-1:0] factor_q;
    logic                half_q;
    logic                settled;

    rsd_cfg #(.FACTOR_W(FACTOR_W), .CFG_W(CFG_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .enable(enable), .wr(cfg_wr),
        .factor_in(cfg_factor), .half_in(cfg_half),
        .factor_q(factor_q), .half_q(half_q)
    );

    rsd_settle #(.LIMIT(SETTLE_TICKS)) u_settle (
        .clk(clk), .rst_n(rst_n), .enable(enable), .settled(settled)
    );

    rsd_delay #(.FACTOR_W(FACTOR_W), .OVERSAMPLE(OVERSAMPLE)) u_delay (
        .clk(clk), .rst_n(rst_n), .enable(enable), .factor(factor_q),
        .half(half_q), .strobe(strobe_rise), .capture(capture)
    );

    assign ready = enable && settled;
endmodule

// File: rtl/rsd_checker.sv
module rsd_checker #(
    parameter int unsigned FACTOR_W = 4,
    parameter int unsigned LIMIT    = 1024
) (
    input logic                clk,
    input logic                rst_n,
    input logic                enable,
    input logic                strobe_rise,
    input logic                capture,
    input logic                ready,
    input logic [FACTOR_W-1:0] factor_q,
    input logic                half_q
);
    localparam int unsigned CW = $clog2(LIMIT + 1);
    logic [CW-1:0] en_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                       en_run <= '0;
        else if (!enable)                 en_run <= '0;
        else if (en_run != CW'(LIMIT))    en_run <= en_run + 1'b1;
    end

    a_r2_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        enable |=> ($stable(factor_q) && $stable(half_q)));

    a_r4_settle_window: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (en_run == CW'(LIMIT)));

    a_r7_zero_factor: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && factor_q == '0 && strobe_rise) |-> capture);

    a_r8_disabled_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> (capture == strobe_rise && !ready));

    a_r9_no_early_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && factor_q != '0 && strobe_rise) |-> !capture);
endmodule

bind rd_sample_delay rsd_checker #(
    .FACTOR_W(FACTOR_W), .LIMIT(SETTLE_CLKS * OVERSAMPLE)
) u_chk (
    .clk(clk), .rst_n(rst_n), .enable(enable), .strobe_rise(strobe_rise),
    .capture(capture), .ready(ready), .factor_q(factor_q), .half_q(half_q)
);

// File: tb/rd_sample_delay_bench.sv
module rd_sample_delay_bench;
    localparam int CLK_PERIOD = 10;
    localparam int SETTLE     = 64 * 16;
    localparam int WINDOW     = 40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [5:0] cfg_factor = '0;
    logic       cfg_half = 1'b0;
    logic       strobe_rise = 1'b0;
    logic       capture;
    logic       ready;

    int  n_chk = 0;
    int  n_bad = 0;
    logic cap_s, rdy_s;

    rd_sample_delay u_rd_sample_delay (
        .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_wr(cfg_wr),
        .cfg_factor(cfg_factor), .cfg_half(cfg_half),
        .strobe_rise(strobe_rise), .capture(capture), .ready(ready)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic int exp_delay(input bit en, input int raw, input bit half);
        int f;
        f = (raw > 15) ? 15 : raw;
        if (!en || f == 0) return 0;
        return half ? f : 2 * f;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input bit en, input bit wr, input int f, input bit h, input bit strb);
        @(negedge clk);
        enable      = en;
        cfg_wr      = wr;
        cfg_factor  = 6'(f);
        cfg_half    = h;
        strobe_rise = strb;
        #1;
        cap_s = capture;
        rdy_s = ready;
    endtask

    task automatic configure(input int f, input bit h);
        cyc(0, 1, f, h, 0);
        cyc(0, 0, 0, 0, 0);
    endtask

    task automatic measure(input bit en, output int off, output int cnt);
        off = -1;
        cnt = 0;
        cyc(en, 0, 0, 0, 1);
        if (cap_s) begin off = 0; cnt++; end
        for (int k = 1; k <= WINDOW; k++) begin
            cyc(en, 0, 0, 0, 0);
            if (cap_s) begin
                if (off < 0) off = k;
                cnt++;
            end
        end
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        int off, cnt, e, raw, raw2;
        bit h, h2;
        void'($urandom(32'd20240917));

        // R1: reset state
        #(CLK_PERIOD * 3 + 2);
        check(capture == 1'b0, "R1 capture after reset", int'(capture), 0);
        check(ready == 1'b0, "R1 ready after reset", int'(ready), 0);
        rst_n = 1'b1;
        measure(1, off, cnt);
        check(off == 0 && cnt == 1, "R1 zero config captures at once", off, 0);

        // R8: disabled bypass, ready low
        configure(9, 0);
        measure(0, off, cnt);
        check(off == 0 && cnt == 1, "R8 disabled capture at strobe", off, 0);
        check(rdy_s == 1'b0, "R8 ready low while disabled", int'(rdy_s), 0);

        // R5 / R6 directed
        measure(1, off, cnt);
        check(off == 18 && cnt == 1, "R5 full mode factor 9", off, 18);
        configure(1, 1);
        measure(1, off, cnt);
        check(off == 1 && cnt == 1, "R6 half mode factor 1", off, 1);
        configure(15, 1);
        measure(1, off, cnt);
        check(off == 15 && cnt == 1, "R6 half mode factor 15", off, 15);

        // R3 saturation
        configure(40, 0);
        measure(1, off, cnt);
        check(off == 30 && cnt == 1, "R3 factor 40 saturates to 15", off, 30);
        configure(16, 1);
        measure(1, off, cnt);
        check(off == 15 && cnt == 1, "R3 factor 16 saturates to 15", off, 15);

        // R7 explicit zero factor
        configure(0, 1);
        measure(1, off, cnt);
        check(off == 0 && cnt == 1, "R7 zero factor enabled", off, 0);

        // R2 write while enabled ignored
        configure(3, 0);
        cyc(1, 1, 12, 1, 0);
        measure(1, off, cnt);
        check(off == 6 && cnt == 1, "R2 enabled write ignored", off, 6);

        // R8 cancel pending on disable
        configure(10, 0);
        cyc(1, 0, 0, 0, 1);
        cnt = 0;
        for (int k = 0; k < 4; k++) cyc(1, 0, 0, 0, 0);
        for (int k = 0; k < 30; k++) begin
            cyc(0, 0, 0, 0, 0);
            if (cap_s) cnt++;
        end
        check(cnt == 0, "R8 pending capture cancelled", cnt, 0);

        // R9 restart on second strobe
        configure(10, 0);
        cyc(1, 0, 0, 0, 1);
        for (int k = 0; k < 2; k++) cyc(1, 0, 0, 0, 0);
        measure(1, off, cnt);
        check(off == 20 && cnt == 1, "R9 restart from newer strobe", off, 20);

        // R4 settling window
        cyc(0, 0, 0, 0, 0);
        cyc(1, 0, 0, 0, 0);
        for (int k = 1; k < SETTLE; k++) begin
            cyc(1, 0, 0, 0, 0);
            if (k < SETTLE - 1 && rdy_s) begin
                check(1'b0, "R4 ready early", k, SETTLE);
                break;
            end
        end
        check(rdy_s == 1'b0, "R4 ready low at 1023 ticks", int'(rdy_s), 0);
        cyc(1, 0, 0, 0, 0);
        check(rdy_s == 1'b1, "R4 ready high at 1024 ticks", int'(rdy_s), 1);
        cyc(0, 0, 0, 0, 0);
        check(rdy_s == 1'b0, "R8 ready drops with enable", int'(rdy_s), 0);

        // random configurations, each with an ignored enabled write (R2)
        for (int i = 0; i < 40; i++) begin
            raw  = int'($urandom % 64);
            h    = 1'($urandom % 2);
            raw2 = int'($urandom % 64);
            h2   = 1'($urandom % 2);
            configure(raw, h);
            cyc(1, 1, raw2, h2, 0);
            e = exp_delay(1, raw, h);
            measure(1, off, cnt);
            check(off == e && cnt == 1, h ? "R6 random half mode" : "R5 random full mode", off, e);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule